// File: doc/BRIEF.md
# Serial NOR Flash Command Target

This block is the command side of a serial NOR flash device. A byte-level serial front end hands it one received byte at a time. The block returns a response byte, and the host collects that byte during the following transfer. Each chip-select frame carries one opcode. Commands with an address take three address bytes, high byte first. The block then reads data out, programs bytes, or erases a region of its internal array. It also keeps a write-enable latch, and it answers status and identification queries.

The array size, the small erase granularity and the large erase granularity are parameters. The defaults are scaled down so that simulation stays fast. Bit shifting, clock-mode handling, busy timing and non-volatile backing are handled elsewhere or not modelled.

The command state machine has these states:
- `ST_IDLE`: waits for an opcode.
- `ST_ADDR`: collects the three address bytes.
- `ST_DUMMY`: swallows the fast-read filler byte.
- `ST_READ`: streams data out.
- `ST_PROG`: programs incoming bytes.
- `ST_ID`: returns the identification bytes.
- `ST_DONE`: ignores the rest of the frame.

Its transitions are:
- `ST_IDLE` to `ST_ADDR` on a read, fast-read, program, sector-erase or block-erase opcode.
- `ST_IDLE` to `ST_ID` on the identification opcode.
- `ST_IDLE` to `ST_DONE` on a write-enable, write-disable, status, chip-erase or unknown opcode.
- `ST_IDLE` stays in `ST_IDLE` on opcode 0x00.
- `ST_ADDR` to `ST_READ` (read), `ST_DUMMY` (fast read), `ST_PROG` (program with the latch set) or `ST_DONE` (erase, or program with the latch clear), taken on the third address byte.
- `ST_DUMMY` to `ST_READ`.
- `ST_ID` to `ST_DONE` after the third identification byte has been produced.
- Any state to `ST_IDLE` when chip select is dropped.

Top module: `spi_nor_target`

## Requirements
- R1: After reset every array byte reads 0xFF, the write-enable latch is clear, and the response byte is 0xFF.
- R2: Opcode 0x03 followed by three address bytes (most significant first) returns the byte at that address on the next transfer, then successive bytes. The address wraps from the last array byte to 0. Address bits above the array size are ignored.
- R3: Opcode 0x0B takes three address bytes plus one filler byte of any value. Data starts on the transfer after the filler, with the same addressing as R2.
- R4: Opcode 0x02 with three address bytes stores each later byte as old AND new, so bits can only be cleared. The address increments after each byte. Nothing is stored when the write-enable latch is clear.
- R5: Opcode 0x20 with an address sets the SECTOR_BYTES-aligned region containing that address to 0xFF, only when the latch is set.
- R6: Opcode 0x52 with an address sets the BLOCK_BYTES-aligned region containing that address to 0xFF, only when the latch is set. Bytes outside the region keep their value.
- R7: Opcode 0xC7 sets the whole array to 0xFF when the latch is set, and does nothing otherwise.
- R8: Opcode 0x06 sets the write-enable latch and 0x04 clears it. The latch also clears after an erase is carried out, and at the end of a frame that reached its program data phase.
- R9: Opcode 0x05 makes the next response byte carry the latch in bit 1, with all other bits 0.
- R10: Opcode 0x9F makes the next three responses 0xEF, 0x40, 0x17 in that order. Later responses in the frame are 0xFF.
- R11: Dropping chip select discards any partial command, so the next frame starts with a fresh opcode. The response is 0xFF while the block is deselected.
- R12: An unknown opcode makes the rest of the frame ignored, with every response 0xFF. Opcode 0x00 leaves the block waiting for an opcode.
- R13: The response byte changes only on a received byte or on deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select, active high |
| rx_valid_i | input | 1 | One-cycle strobe: a byte was received |
| rx_byte_i | input | 8 | Received byte |
| tx_byte_o | output | 8 | Response byte for the next transfer |

## Verification
The assertions follow the response port on every cycle. They check that it idles at 0xFF while the block is deselected, and that it holds still between received bytes. They also check the first response after an identification, status or unknown opcode, using a small frame-start tracker in the checker. Array contents are only visible through read frames, so the bench's scenarios are what show:
- AND-only programming.
- Erase region alignment and extent.
- Address wrap and high-bit masking.
- The write-enable gating.
- Abort on deselect.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DUMMY,
        ST_READ,
        ST_PROG,
        ST_ID,
        ST_DONE
    } nor_state_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_FAST,
        CMD_PROG,
        CMD_SECTOR,
        CMD_BLOCK
    } nor_cmd_e;

    typedef enum logic [1:0] {
        ER_SECTOR,
        ER_BLOCK,
        ER_CHIP
    } erase_kind_e;

    localparam logic [7:0] OPC_NOP    = 8'h00;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_WDIS   = 8'h04;
    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_WEN    = 8'h06;
    localparam logic [7:0] OPC_FAST   = 8'h0B;
    localparam logic [7:0] OPC_SECTOR = 8'h20;
    localparam logic [7:0] OPC_BLOCK  = 8'h52;
    localparam logic [7:0] OPC_ID     = 8'h9F;
    localparam logic [7:0] OPC_CHIP   = 8'hC7;

    localparam logic [7:0] ID_BYTE0 = 8'hEF;
    localparam logic [7:0] ID_BYTE1 = 8'h40;
    localparam logic [7:0] ID_BYTE2 = 8'h17;
    localparam logic [7:0] FILL     = 8'hFF;

endpackage

// File: rtl/spi_nor_storage.sv
module spi_nor_storage
    import spi_nor_pkg::*;
#(
    parameter int unsigned MEM_BYTES    = 1024,
    parameter int unsigned SECTOR_BYTES = 128,
    parameter int unsigned BLOCK_BYTES  = 512,
    localparam int unsigned AW = $clog2(MEM_BYTES),
    localparam int unsigned SW = $clog2(SECTOR_BYTES),
    localparam int unsigned BW = $clog2(BLOCK_BYTES)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [AW-1:0]       rd_addr_i,
    output logic [7:0]          rd_data_o,
    input  logic                wr_en_i,
    input  logic [AW-1:0]       wr_addr_i,
    input  logic [7:0]          wr_data_i,
    input  logic                er_en_i,
    input  erase_kind_e         er_kind_i,
    input  logic [AW-SW-1:0]    er_idx_i
);

    logic [MEM_BYTES-1:0][7:0] cell_w;

    for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
        localparam int unsigned SEC_ID = g / SECTOR_BYTES;
        localparam int unsigned BLK_ID = g / BLOCK_BYTES;

        logic [7:0] byte_q;
        logic       sec_hit;
        logic       blk_hit;
        logic       wipe;

        assign sec_hit = (er_idx_i == (AW-SW)'(SEC_ID));
        assign blk_hit = (er_idx_i[AW-SW-1:BW-SW] == (AW-BW)'(BLK_ID));
        assign wipe    = er_en_i && ((er_kind_i == ER_CHIP)
                                  || (er_kind_i == ER_SECTOR && sec_hit)
                                  || (er_kind_i == ER_BLOCK  && blk_hit));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                byte_q <= FILL;
            end else if (wipe) begin
                byte_q <= FILL;
            end else if (wr_en_i && wr_addr_i == AW'(g)) begin
                byte_q <= byte_q & wr_data_i;
            end
        end

        assign cell_w[g] = byte_q;
    end

    assign rd_data_o = cell_w[rd_addr_i];

endmodule

// File: rtl/spi_nor_cmd_fsm.sv
module spi_nor_cmd_fsm
    import spi_nor_pkg::*;
#(
    parameter int unsigned MEM_BYTES    = 1024,
    parameter int unsigned SECTOR_BYTES = 128,
    localparam int unsigned AW = $clog2(MEM_BYTES),
    localparam int unsigned SW = $clog2(SECTOR_BYTES)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sel_i,
    input  logic                rx_valid_i,
    input  logic [7:0]          rx_byte_i,
    input  logic [7:0]          rd_data_i,
    output logic [AW-1:0]       rd_addr_o,
    output logic                wr_en_o,
    output logic [AW-1:0]       wr_addr_o,
    output logic [7:0]          wr_data_o,
    output logic                er_en_o,
    output erase_kind_e         er_kind_o,
    output logic [AW-SW-1:0]    er_idx_o,
    output logic [7:0]          tx_o
);

    nor_state_e    state_q, state_d;
    nor_cmd_e      op_q, op_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [1:0]    cnt_q, cnt_d;
    logic [1:0]    id_q, id_d;
    logic [7:0]    tx_q, tx_d;
    logic          wel_q, wel_d;
    logic [AW-1:0] full_addr;

    // address shift: only the low AW bits survive, higher bits are dropped
    assign full_addr = {addr_q[AW-9:0], rx_byte_i};
    assign rd_addr_o = (state_q == ST_ADDR) ? full_addr : addr_q;
    assign wr_addr_o = addr_q;
    assign wr_data_o = rx_byte_i;
    assign er_idx_o  = full_addr[AW-1:SW];
    assign tx_o      = tx_q;

    always_comb begin
        state_d   = state_q;
        op_d      = op_q;
        addr_d    = addr_q;
        cnt_d     = cnt_q;
        id_d      = id_q;
        tx_d      = tx_q;
        wel_d     = wel_q;
        wr_en_o   = 1'b0;
        er_en_o   = 1'b0;
        er_kind_o = ER_CHIP;

        if (!sel_i) begin
            state_d = ST_IDLE;
            cnt_d   = 2'd0;
            tx_d    = FILL;
            if (state_q == ST_PROG) begin
                wel_d = 1'b0;
            end
        end else if (rx_valid_i) begin
            tx_d = FILL;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d = 2'd0;
                    case (rx_byte_i)
                        OPC_NOP:    ;
                        OPC_PROG:   begin op_d = CMD_PROG;   state_d = ST_ADDR; end
                        OPC_READ:   begin op_d = CMD_READ;   state_d = ST_ADDR; end
                        OPC_FAST:   begin op_d = CMD_FAST;   state_d = ST_ADDR; end
                        OPC_SECTOR: begin op_d = CMD_SECTOR; state_d = ST_ADDR; end
                        OPC_BLOCK:  begin op_d = CMD_BLOCK;  state_d = ST_ADDR; end
                        OPC_WEN:    begin wel_d = 1'b1; state_d = ST_DONE; end
                        OPC_WDIS:   begin wel_d = 1'b0; state_d = ST_DONE; end
                        OPC_STATUS: begin
                            tx_d    = {6'b0, wel_q, 1'b0};
                            state_d = ST_DONE;
                        end
                        OPC_ID: begin
                            tx_d    = ID_BYTE0;
                            id_d    = 2'd1;
                            state_d = ST_ID;
                        end
                        OPC_CHIP: begin
                            if (wel_q) begin
                                er_en_o   = 1'b1;
                                er_kind_o = ER_CHIP;
                                wel_d     = 1'b0;
                            end
                            state_d = ST_DONE;
                        end
                        default: state_d = ST_DONE;
                    endcase
                end
                ST_ADDR: begin
                    addr_d = full_addr;
                    cnt_d  = cnt_q + 2'd1;
                    if (cnt_q == 2'd2) begin
                        case (op_q)
                            CMD_READ: begin
                                tx_d    = rd_data_i;
                                addr_d  = full_addr + AW'(1);
                                state_d = ST_READ;
                            end
                            CMD_FAST: state_d = ST_DUMMY;
                            CMD_PROG: state_d = wel_q ? ST_PROG : ST_DONE;
                            default: begin
                                if (wel_q) begin
                                    er_en_o   = 1'b1;
                                    er_kind_o = (op_q == CMD_SECTOR) ? ER_SECTOR : ER_BLOCK;
                                    wel_d     = 1'b0;
                                end
                                state_d = ST_DONE;
                            end
                        endcase
                    end
                end
                ST_DUMMY: begin
                    tx_d    = rd_data_i;
                    addr_d  = addr_q + AW'(1);
                    state_d = ST_READ;
                end
                ST_READ: begin
                    tx_d   = rd_data_i;
                    addr_d = addr_q + AW'(1);
                end
                ST_PROG: begin
                    wr_en_o = 1'b1;
                    addr_d  = addr_q + AW'(1);
                end
                ST_ID: begin
                    tx_d = (id_q == 2'd1) ? ID_BYTE1 : ID_BYTE2;
                    id_d = id_q + 2'd1;
                    if (id_q == 2'd2) begin
                        state_d = ST_DONE;
                    end
                end
                ST_DONE: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            op_q    <= CMD_READ;
            addr_q  <= '0;
            cnt_q   <= 2'd0;
            id_q    <= 2'd0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            addr_q  <= addr_d;
            cnt_q   <= cnt_d;
            id_q    <= id_d;
        end
    end

    // output and latch register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_q  <= FILL;
            wel_q <= 1'b0;
        end else begin
            tx_q  <= tx_d;
            wel_q <= wel_d;
        end
    end

endmodule

// File: rtl/spi_nor_target.sv
module spi_nor_target
    import spi_nor_pkg::*;
#(
    parameter int unsigned MEM_BYTES    = 1024,
    parameter int unsigned SECTOR_BYTES = 128,
    parameter int unsigned BLOCK_BYTES  = 512
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sel_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    output logic [7:0] tx_byte_o
);

    localparam int unsigned AW = $clog2(MEM_BYTES);
    localparam int unsigned SW = $clog2(SECTOR_BYTES);

    logic [AW-1:0]    rd_addr;
    logic [7:0]       rd_data;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [7:0]       wr_data;
    logic             er_en;
    erase_kind_e      er_kind;
    logic [AW-SW-1:0] er_idx;

    spi_nor_cmd_fsm #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_i      (sel_i),
        .rx_valid_i (rx_valid_i),
        .rx_byte_i  (rx_byte_i),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .er_en_o    (er_en),
        .er_kind_o  (er_kind),
        .er_idx_o   (er_idx),
        .tx_o       (tx_byte_o)
    );

    spi_nor_storage #(
        .MEM_BYTES    (MEM_BYTES),
        .SECTOR_BYTES (SECTOR_BYTES),
        .BLOCK_BYTES  (BLOCK_BYTES)
    ) i_storage (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .er_en_i   (er_en),
        .er_kind_i (er_kind),
        .er_idx_i  (er_idx)
    );

endmodule

// File: rtl/spi_nor_target_chk.sv
module spi_nor_target_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sel_i,
    input logic       rx_valid_i,
    input logic [7:0] rx_byte_i,
    input logic [7:0] tx_byte_o
);

    // tracks whether the next received byte is decoded as an opcode
    logic first_q;
    logic opc_strobe;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            first_q <= 1'b1;
        end else if (!sel_i) begin
            first_q <= 1'b1;
        end else if (rx_valid_i && rx_byte_i != 8'h00) begin
            first_q <= 1'b0;
        end
    end

    assign opc_strobe = first_q && sel_i && rx_valid_i;

    AST_DESELECT_IDLE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> tx_byte_o == 8'hFF); // R11

    AST_RESP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && !rx_valid_i) |=> $stable(tx_byte_o)); // R13

    AST_ID_LEAD_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_strobe && rx_byte_i == 8'h9F) |=> tx_byte_o == 8'hEF); // R10

    AST_STATUS_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_strobe && rx_byte_i == 8'h05) |=> (tx_byte_o[7:2] == 6'b0 && !tx_byte_o[0])); // R9

    AST_UNKNOWN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (opc_strobe && !(rx_byte_i inside {8'h00, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
                                           8'h0B, 8'h20, 8'h52, 8'h9F, 8'hC7}))
        |=> tx_byte_o == 8'hFF); // R12

endmodule

bind spi_nor_target spi_nor_target_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .tx_byte_o  (tx_byte_o)
);

// File: tb/test_spi_nor_target.sv
module test_spi_nor_target;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_byte;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_nor_target i_spi_nor_target (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sel_i      (sel),
        .rx_valid_i (rx_valid),
        .rx_byte_i  (rx_byte),
        .tx_byte_o  (tx_byte)
    );

    // {req[3:0], byte in, expected response, check, last in frame}
    localparam logic [21:0] VEC [NVEC] = '{
        // R10 identification frame (first response is the idle fill, R1)
        {4'd1,  8'h9F, 8'hFF, 1'b1, 1'b0},
        {4'd10, 8'h00, 8'hEF, 1'b1, 1'b0},
        {4'd10, 8'h00, 8'h40, 1'b1, 1'b0},
        {4'd10, 8'h00, 8'h17, 1'b1, 1'b0},
        {4'd10, 8'h00, 8'hFF, 1'b1, 1'b1},
        // R9 status with latch clear
        {4'd9,  8'h05, 8'hFF, 1'b0, 1'b0},
        {4'd9,  8'h00, 8'h00, 1'b1, 1'b1},
        // R8 write enable, then status shows bit 1
        {4'd8,  8'h06, 8'hFF, 1'b0, 1'b1},
        {4'd8,  8'h05, 8'hFF, 1'b0, 1'b0},
        {4'd8,  8'h00, 8'h02, 1'b1, 1'b1},
        // R4 program 0x000110 with A5, 3C
        {4'd4,  8'h02, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'h00, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'h01, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'h10, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'hA5, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'h3C, 8'hFF, 1'b0, 1'b1},
        // R2 read back
        {4'd2,  8'h03, 8'hFF, 1'b0, 1'b0},
        {4'd2,  8'h00, 8'hFF, 1'b0, 1'b0},
        {4'd2,  8'h01, 8'hFF, 1'b0, 1'b0},
        {4'd2,  8'h10, 8'hFF, 1'b0, 1'b0},
        {4'd2,  8'h00, 8'hA5, 1'b1, 1'b0},
        {4'd2,  8'h00, 8'h3C, 1'b1, 1'b0},
        {4'd2,  8'h00, 8'hFF, 1'b1, 1'b1},
        // R8 latch cleared by the program frame
        {4'd8,  8'h05, 8'hFF, 1'b0, 1'b0},
        {4'd8,  8'h00, 8'h00, 1'b1, 1'b1},
        // R4 program with latch clear is ignored
        {4'd4,  8'h02, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'h00, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'h01, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'h10, 8'hFF, 1'b0, 1'b0},
        {4'd4,  8'h00, 8'hFF, 1'b0, 1'b1},
        // R3 fast read with filler 0x77
        {4'd3,  8'h0B, 8'hFF, 1'b0, 1'b0},
        {4'd3,  8'h00, 8'hFF, 1'b0, 1'b0},
        {4'd3,  8'h01, 8'hFF, 1'b0, 1'b0},
        {4'd3,  8'h10, 8'hFF, 1'b0, 1'b0},
        {4'd3,  8'h77, 8'hFF, 1'b1, 1'b0},
        {4'd3,  8'h00, 8'hA5, 1'b1, 1'b0},
        {4'd3,  8'h00, 8'h3C, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic frame_on();
        @(negedge clk);
        sel = 1'b1;
    endtask

    task automatic frame_off();
        @(negedge clk);
        sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] d, output logic [7:0] r);
        @(negedge clk);
        r        = tx_byte;
        rx_valid = 1'b1;
        rx_byte  = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        frame_on();
        xfer(op, r);
        frame_off();
    endtask

    task automatic read2(input logic [23:0] a, output logic [7:0] d0, output logic [7:0] d1);
        logic [7:0] r;
        frame_on();
        xfer(8'h03, r);
        xfer(a[23:16], r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
        xfer(8'h00, d0);
        xfer(8'h00, d1);
        frame_off();
    endtask

    task automatic prog2(input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1);
        logic [7:0] r;
        frame_on();
        xfer(8'h02, r);
        xfer(a[23:16], r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
        xfer(d0, r);
        xfer(d1, r);
        frame_off();
    endtask

    task automatic erase(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        frame_on();
        xfer(op, r);
        xfer(a[23:16], r);
        xfer(a[15:8], r);
        xfer(a[7:0], r);
        frame_off();
    endtask

    task automatic status(output logic [7:0] s);
        logic [7:0] r;
        frame_on();
        xfer(8'h05, r);
        xfer(8'h00, s);
        frame_off();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] a, b, r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset response", tx_byte, 8'hFF);

        for (int i = 0; i < NVEC; i++) begin
            if (!sel) frame_on();
            xfer(VEC[i][17:10], r);
            if (VEC[i][1]) begin
                n_chk++;
                if (r !== VEC[i][9:2]) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d: got %02h expected %02h",
                             VEC[i][21:18], i, r, VEC[i][9:2]);
                end
            end
            if (VEC[i][0]) frame_off();
        end

        // R13 response holds between transfers; R11 fill when deselected
        frame_on();
        xfer(8'h9F, r);
        repeat (5) @(negedge clk);
        check("R13 hold between transfers", tx_byte, 8'hEF);
        frame_off();
        check("R11 deselected response", tx_byte, 8'hFF);

        // R4 AND-only programming
        cmd1(8'h06);
        prog2(24'h000110, 8'h0F, 8'hFF);
        read2(24'h000110, a, b);
        check("R4 and-program", a, 8'h05);
        check("R4 ff keeps byte", b, 8'h3C);

        // R2 wrap at end of array, upper address bits ignored
        cmd1(8'h06);
        prog2(24'h0003FF, 8'h12, 8'h34);
        read2(24'h0003FF, a, b);
        check("R2 last byte", a, 8'h12);
        check("R2 wrap to zero", b, 8'h34);
        read2(24'hF403FF, a, b);
        check("R2 high bits ignored", a, 8'h12);
        check("R2 high bits wrap", b, 8'h34);

        // R5 sector erase aligned down
        cmd1(8'h06);
        prog2(24'h00017F, 8'h66, 8'h55);
        cmd1(8'h06);
        erase(8'h20, 24'h000140);
        read2(24'h00017F, a, b);
        check("R5 sector top erased", a, 8'hFF);
        check("R5 next sector kept", b, 8'h55);
        read2(24'h000110, a, b);
        check("R5 sector body erased", a, 8'hFF);
        check("R5 sector body erased", b, 8'hFF);
        erase(8'h20, 24'h000180);
        read2(24'h00017F, a, b);
        check("R5 erase without latch ignored", b, 8'h55);

        // R6 block erase
        cmd1(8'h06);
        erase(8'h52, 24'h000201);
        read2(24'h0003FF, a, b);
        check("R6 block erased", a, 8'hFF);
        check("R6 other block kept", b, 8'h34);
        read2(24'h00017F, a, b);
        check("R6 lower block kept", b, 8'h55);
        status(r);
        check("R8 latch clear after erase", r, 8'h00);

        // R11 abort partial command
        cmd1(8'h06);
        frame_on();
        xfer(8'h02, r);
        xfer(8'h00, r);
        frame_off();
        status(r);
        check("R11 aborted program keeps latch", r, 8'h02);
        frame_on();
        xfer(8'h9F, r);
        xfer(8'h00, r);
        frame_off();
        check("R11 fresh opcode after abort", r, 8'hEF);
        cmd1(8'h04);
        status(r);
        check("R8 write disable", r, 8'h00);

        // R12 unknown opcode and no-op
        frame_on();
        xfer(8'hAB, r);
        xfer(8'h9F, r);
        check("R12 unknown response", r, 8'hFF);
        xfer(8'h00, r);
        check("R12 rest ignored", r, 8'hFF);
        frame_off();
        frame_on();
        xfer(8'h00, r);
        xfer(8'h9F, r);
        xfer(8'h00, r);
        frame_off();
        check("R12 no-op then opcode", r, 8'hEF);

        // R7 chip erase
        cmd1(8'hC7);
        read2(24'h00017F, a, b);
        check("R7 chip erase without latch", b, 8'h55);
        cmd1(8'h06);
        cmd1(8'hC7);
        read2(24'h00017F, a, b);
        check("R7 chip erase clears", b, 8'hFF);
        read2(24'h0003FF, a, b);
        check("R7 chip erase clears wrap", b, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule